// File: doc/BRIEF.md
# Carrier Module-Space Address Decoder

This block sits between a host-side access port and up to four plug-in module slots on a carrier. A host access arrives as a one-cycle strobe that names one of four windows: a byte-wide configuration window, a 1 KiB register window that splits each slot into I/O, identification and interrupt spaces, a 16-bit memory window and an 8-bit memory window. The decoder works out the slot, the space and the offset. For the register and 16-bit windows it applies a big-endian adjustment when that window's flag is set. It then issues a single-cycle request to the module side and waits for that side's completion strobe.

Accesses that no module can serve complete locally on the next cycle with zero data and without a module request. These are accesses to an empty slot, to the configuration window, and accesses whose size the window does not support. Reads from two fixed offsets of a slot's interrupt space also acknowledge a level-sensitive interrupt line of that slot, shown by a one-cycle pulse on the acknowledge vector. The endianness flags are single bits in the configuration window. One of them only drives an output for a neighbouring control window.

Top module: `modspace_decoder`

## Requirements
- R1: In the register window (`host_win`=1), address bits [9:8] give `mod_slot`. Bits [7:6] give the space: 2 selects ID (`mod_space`=1), 3 selects interrupt (`mod_space`=2), and 0 or 1 select I/O (`mod_space`=0).
- R2: The register-window offset is address bits [6:0] for I/O space and bits [5:0] for ID and interrupt space. Higher offset bits are zero.
- R3: When a window's big-endian flag is set, a byte access (`host_size`=0) to the register or 16-bit window has address bit 0 inverted before decoding.
- R4: When a window's big-endian flag is set, a halfword access (`host_size`=1) to the register or 16-bit window presents `mod_wdata` with its two bytes swapped. Read data comes back to `host_rdata` swapped the same way.
- R5: A register-window read of interrupt-space offset 0 or 2 of a populated slot s pulses `int_ack[2*s+line]` for one cycle, together with the module request. Offset 0 is line 0 and offset 2 is line 1. The pulse fires only when `irq_status` for that bit is 1 and `irq_edge` for that bit is 0. Any other offset gives no pulse.
- R6: The 16-bit window (`host_win`=2, `mod_space`=3) takes the slot from address bits [24:23] and the offset from bits [22:0]. The 8-bit window (`host_win`=3, `mod_space`=4) takes the slot from bits [23:22] and the offset from bits [21:0], and it never applies an endian adjustment.
- R7: An access to a slot whose `slot_present` bit is 0 issues no module request. It completes with `host_ack` in the cycle after the strobe, and `host_rdata` is zero.
- R8: A byte write to configuration byte 0x2B, 0x2F or 0x33 (`host_win`=0, address bits [6:0]) loads `host_wdata` bit 0 into the control-window flag (`be_ctl`), the register-window flag or the 16-bit-window flag respectively. A byte read of those bytes returns the flag in bit 0. Other configuration bytes read zero, and writes to them change no flag.
- R9: A halfword access to the 8-bit window or the configuration window is rejected. It makes no request, changes no flag, and completes in the next cycle with zero data.
- R10: Each module-bound access gives one single-cycle `mod_req`. `host_ack` pulses once, in the cycle after `mod_done` is seen. Writes return zero on `host_rdata`.
- R11: After reset all flags are clear and `host_ack`, `mod_req` and `int_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | One-cycle access strobe |
| host_win | input | 2 | Window: 0 config, 1 register, 2 16-bit memory, 3 8-bit memory |
| host_we | input | 1 | 1 = write |
| host_size | input | 1 | 0 = byte, 1 = halfword |
| host_addr | input | 25 | Byte address within the window |
| host_wdata | input | 16 | Write data |
| host_ack | output | 1 | Completion pulse |
| host_rdata | output | 16 | Read data, valid with `host_ack` |
| slot_present | input | 4 | One bit per populated slot |
| irq_status | input | 8 | Interrupt line status, bit 2*slot+line |
| irq_edge | input | 8 | 1 = line is edge sensitive, bit 2*slot+line |
| int_ack | output | 8 | One-cycle acknowledge pulse per line |
| be_ctl | output | 1 | Big-endian flag for the neighbouring control window |
| mod_req | output | 1 | One-cycle module request |
| mod_slot | output | 2 | Target slot |
| mod_space | output | 3 | 0 I/O, 1 ID, 2 interrupt, 3 16-bit memory, 4 8-bit memory |
| mod_offset | output | 23 | Offset within the space |
| mod_we | output | 1 | 1 = write |
| mod_half | output | 1 | 1 = halfword |
| mod_wdata | output | 16 | Write data after lane adjustment |
| mod_done | input | 1 | Module completion strobe |
| mod_rdata | input | 16 | Module read data, valid with `mod_done` |

## Verification
The assertions assume the host raises no new strobe while an access is outstanding. They also assume `mod_done` comes only after a request, and that `slot_present` holds steady while an access is in flight. The bench drives one access at a time and waits for `host_ack` before it goes on, so the first assumption holds. Its module model answers only a request it has seen, so `mod_done` never arrives unasked. `slot_present`, `irq_status` and `irq_edge` stay fixed for the whole run, which covers the last assumption.

// File: rtl/md_pkg.sv
package md_pkg;
  localparam int ADDR_W   = 25;
  localparam int DATA_W   = 16;
  localparam int NSLOT    = 4;
  localparam int SLOT_W   = $clog2(NSLOT);
  localparam int LINES    = 2;
  localparam int NIRQ     = NSLOT * LINES;
  localparam int OFF_W    = 23;
  localparam int CFG_AW   = 7;
  localparam int NFLAG    = 3;
  localparam int FLAG_BASE = 'h2B;
  localparam int FLAG_STEP = 4;

  typedef enum logic [1:0] {WIN_CFG = 2'd0, WIN_REG = 2'd1, WIN_M16 = 2'd2, WIN_M8 = 2'd3} win_e;
  typedef enum logic [2:0] {SP_IO = 3'd0, SP_ID = 3'd1, SP_INT = 3'd2, SP_M16 = 3'd3, SP_M8 = 3'd4} space_e;

  function automatic logic [DATA_W-1:0] lane_swap(input logic [DATA_W-1:0] d);
    return {d[7:0], d[15:8]};
  endfunction

  function automatic int flag_addr(input int idx);
    return FLAG_BASE + FLAG_STEP * idx;
  endfunction
endpackage

// File: rtl/md_cfg_flags.sv
module md_cfg_flags
  import md_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CFG_AW-1:0] addr,
  input  logic              wbit,
  output logic [NFLAG-1:0]  flags,
  output logic              rd_bit
);
  logic [NFLAG-1:0] hit;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    assign hit[g] = (addr == CFG_AW'(flag_addr(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flags[g] <= 1'b0;
      else if (wr && hit[g]) flags[g] <= wbit;
    end
  end

  assign rd_bit = |(hit & flags);

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(flags)); // R8
endmodule

// File: rtl/md_addr_map.sv
module md_addr_map
  import md_pkg::*;
(
  input  win_e              win,
  input  logic [ADDR_W-1:0] addr,
  input  logic              half,
  input  logic              be_reg,
  input  logic              be_m16,
  input  logic [NSLOT-1:0]  present,
  output logic [SLOT_W-1:0] slot,
  output space_e            space,
  output logic [OFF_W-1:0]  offset,
  output logic              swap,
  output logic              to_module
);
  logic [ADDR_W-1:0] a;
  logic be;
  logic legal;

  always_comb begin
    be    = 1'b0;
    legal = 1'b0;
    case (win)
      WIN_REG: begin be = be_reg; legal = 1'b1; end
      WIN_M16: begin be = be_m16; legal = 1'b1; end
      WIN_M8:  begin be = 1'b0;   legal = !half; end
      default: begin be = 1'b0;   legal = 1'b0; end
    endcase
    a = addr;
    if (be && !half) a[0] = ~a[0];
    swap   = be && half;
    slot   = '0;
    space  = SP_IO;
    offset = '0;
    case (win)
      WIN_REG: begin
        slot = a[9:8];
        case (a[7:6])
          2'd2:    begin space = SP_ID;  offset = OFF_W'(a[5:0]); end
          2'd3:    begin space = SP_INT; offset = OFF_W'(a[5:0]); end
          default: begin space = SP_IO;  offset = OFF_W'(a[6:0]); end
        endcase
      end
      WIN_M16: begin slot = a[24:23]; space = SP_M16; offset = a[22:0]; end
      WIN_M8:  begin slot = a[23:22]; space = SP_M8;  offset = OFF_W'(a[21:0]); end
      default: ;
    endcase
    to_module = legal && present[slot];
  end
endmodule

// File: rtl/md_seq.sv
module md_seq
  import md_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic              host_half,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              to_module,
  input  logic              swap,
  input  logic [SLOT_W-1:0] dec_slot,
  input  space_e            dec_space,
  input  logic [OFF_W-1:0]  dec_offset,
  input  logic              local_bit,
  input  logic              mod_done,
  input  logic [DATA_W-1:0] mod_rdata,
  output logic              accept,
  output logic              busy,
  output logic              mod_req,
  output logic [SLOT_W-1:0] mod_slot,
  output logic [2:0]        mod_space,
  output logic [OFF_W-1:0]  mod_offset,
  output logic              mod_we,
  output logic              mod_half,
  output logic [DATA_W-1:0] mod_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata
);
  logic swap_q;

  assign accept = host_req && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; mod_req <= 1'b0; host_ack <= 1'b0; swap_q <= 1'b0;
      mod_slot <= '0; mod_space <= '0; mod_offset <= '0; mod_we <= 1'b0;
      mod_half <= 1'b0; mod_wdata <= '0; host_rdata <= '0;
    end else begin
      mod_req  <= 1'b0;
      host_ack <= 1'b0;
      if (accept) begin
        if (to_module) begin
          busy       <= 1'b1;
          mod_req    <= 1'b1;
          mod_slot   <= dec_slot;
          mod_space  <= dec_space;
          mod_offset <= dec_offset;
          mod_we     <= host_we;
          mod_half   <= host_half;
          mod_wdata  <= swap ? lane_swap(host_wdata) : host_wdata;
          swap_q     <= swap;
        end else begin
          host_ack   <= 1'b1;
          host_rdata <= DATA_W'(local_bit);
        end
      end else if (busy && mod_done) begin
        busy       <= 1'b0;
        host_ack   <= 1'b1;
        host_rdata <= mod_we ? '0 : (swap_q ? lane_swap(mod_rdata) : mod_rdata);
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mod_req |=> !mod_req); // R10
  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mod_done) |=> host_ack); // R10
  AST_REQ_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    mod_req |-> !host_ack); // R10
endmodule

// File: rtl/modspace_decoder.sv
module modspace_decoder
  import md_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic [1:0]        host_win,
  input  logic              host_we,
  input  logic              host_size,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [NSLOT-1:0]  slot_present,
  input  logic [NIRQ-1:0]   irq_status,
  input  logic [NIRQ-1:0]   irq_edge,
  output logic [NIRQ-1:0]   int_ack,
  output logic              be_ctl,
  output logic              mod_req,
  output logic [SLOT_W-1:0] mod_slot,
  output logic [2:0]        mod_space,
  output logic [OFF_W-1:0]  mod_offset,
  output logic              mod_we,
  output logic              mod_half,
  output logic [DATA_W-1:0] mod_wdata,
  input  logic              mod_done,
  input  logic [DATA_W-1:0] mod_rdata
);
  localparam int IDX_W = $clog2(NIRQ);

  win_e               win;
  logic [NFLAG-1:0]   flags;
  logic               cfg_bit, cfg_wr, local_bit;
  logic [SLOT_W-1:0]  dec_slot;
  space_e             dec_space;
  logic [OFF_W-1:0]   dec_offset;
  logic               swap, to_module, accept, busy;
  logic [IDX_W-1:0]   ack_idx;
  logic               ack_fire;

  assign win       = win_e'(host_win);
  assign cfg_wr    = accept && win == WIN_CFG && host_we && !host_size;
  assign local_bit = win == WIN_CFG && !host_we && !host_size && cfg_bit;
  assign be_ctl    = flags[0];

  md_cfg_flags u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(host_addr[CFG_AW-1:0]),
    .wbit(host_wdata[0]), .flags(flags), .rd_bit(cfg_bit));

  md_addr_map u_map (
    .win(win), .addr(host_addr), .half(host_size), .be_reg(flags[1]),
    .be_m16(flags[2]), .present(slot_present), .slot(dec_slot),
    .space(dec_space), .offset(dec_offset), .swap(swap), .to_module(to_module));

  md_seq u_seq (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_half(host_size), .host_wdata(host_wdata), .to_module(to_module),
    .swap(swap), .dec_slot(dec_slot), .dec_space(dec_space),
    .dec_offset(dec_offset), .local_bit(local_bit), .mod_done(mod_done),
    .mod_rdata(mod_rdata), .accept(accept), .busy(busy), .mod_req(mod_req),
    .mod_slot(mod_slot), .mod_space(mod_space), .mod_offset(mod_offset),
    .mod_we(mod_we), .mod_half(mod_half), .mod_wdata(mod_wdata),
    .host_ack(host_ack), .host_rdata(host_rdata));

  // Interrupt acknowledge on read of line offsets 0 / 2
  assign ack_idx  = {dec_slot, dec_offset[1]};
  assign ack_fire = accept && to_module && !host_we && win == WIN_REG &&
                    dec_space == SP_INT && dec_offset[5:0] inside {6'd0, 6'd2} &&
                    irq_status[ack_idx] && !irq_edge[ack_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_ack <= '0;
    else begin
      int_ack <= '0;
      if (ack_fire) int_ack[ack_idx] <= 1'b1;
    end
  end

  AST_ACK_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(int_ack)); // R5
  AST_ACK_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack != '0) |-> (mod_req && !mod_we && mod_space == SP_INT)); // R5
  AST_ABSENT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mod_req |-> slot_present[mod_slot]); // R7
  AST_M8_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_req && mod_space == SP_M8) |-> !mod_half); // R9
endmodule

// File: tb/modspace_decoder_tb_top.sv
module modspace_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic [1:0]  host_win = '0;
  logic        host_we = 1'b0;
  logic        host_size = 1'b0;
  logic [24:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_ack;
  logic [15:0] host_rdata;
  logic [3:0]  slot_present = 4'b1011;
  logic [7:0]  irq_status = 8'hFF;
  logic [7:0]  irq_edge = 8'b0000_0010;
  logic [7:0]  int_ack;
  logic        be_ctl;
  logic        mod_req;
  logic [1:0]  mod_slot;
  logic [2:0]  mod_space;
  logic [22:0] mod_offset;
  logic        mod_we, mod_half;
  logic [15:0] mod_wdata;
  logic        mod_done = 1'b0;
  logic [15:0] mod_rdata = '0;

  always #4 clk = ~clk;

  modspace_decoder dut_i (.*);

  typedef struct packed {
    logic [1:0]  slot;
    logic [2:0]  space;
    logic [22:0] offset;
    logic        we;
    logic        half;
    logic [15:0] wdata;
    logic [15:0] rdata;
  } item_t;

  item_t exp_q[$];
  int total = 0;
  int bad = 0;
  logic [7:0] seen_ack;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // module-side monitor and responder
  initial begin
    forever begin
      @(negedge clk);
      mod_done = 1'b0;
      if (int_ack != 0) seen_ack = seen_ack | int_ack;
      if (mod_req) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected mod_req", 1, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(mod_slot == it.slot, "R1", "mod_slot", 32'(mod_slot), 32'(it.slot));
          chk(mod_space == it.space, "R1", "mod_space", 32'(mod_space), 32'(it.space));
          chk(mod_offset == it.offset, "R2", "mod_offset", 32'(mod_offset), 32'(it.offset));
          chk(mod_we == it.we && mod_half == it.half, "R10", "we/half",
              32'({mod_we, mod_half}), 32'({it.we, it.half}));
          if (it.we)
            chk(mod_wdata == it.wdata, "R4", "mod_wdata", 32'(mod_wdata), 32'(it.wdata));
          mod_rdata = it.rdata;
          mod_done  = 1'b1;
        end
      end
    end
  end

  task automatic access(input string req, input logic [1:0] win, input logic we,
                        input logic half, input logic [24:0] addr, input logic [15:0] wd,
                        input bit exp_mod, input item_t it,
                        input logic [15:0] exp_rd, input logic [7:0] exp_ack);
    int n;
    seen_ack = '0;
    if (exp_mod) exp_q.push_back(it);
    @(negedge clk);
    host_req = 1'b1; host_win = win; host_we = we; host_size = half;
    host_addr = addr; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    n = 0;
    while (!host_ack && n < 20) begin @(negedge clk); n++; end
    chk(host_ack == 1'b1, req, "host_ack", 32'(host_ack), 1);
    chk(host_rdata == exp_rd, req, "host_rdata", 32'(host_rdata), 32'(exp_rd));
    if (!exp_mod) chk(n == 0, req, "local completion latency", 32'(n), 0);
    @(negedge clk);
    chk(seen_ack == exp_ack, req, "int_ack", 32'(seen_ack), 32'(exp_ack));
    chk(exp_q.size() == 0, req, "request not issued", 32'(exp_q.size()), 0);
  endtask

  function automatic item_t mk(input logic [1:0] s, input logic [2:0] sp,
                               input logic [22:0] off, input logic we, input logic h,
                               input logic [15:0] wd, input logic [15:0] rd);
    item_t r;
    r.slot = s; r.space = sp; r.offset = off; r.we = we; r.half = h;
    r.wdata = wd; r.rdata = rd;
    return r;
  endfunction

  item_t none;

  initial begin
    none = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!host_ack && !mod_req && int_ack == 0 && !be_ctl, "R11", "reset state",
        32'({host_ack, mod_req, be_ctl, int_ack}), 0);
    // R1 R2 register window decode, flags clear
    access("R1", 2'd1, 0, 1, 25'h17F, 0, 1, mk(1, 0, 23'h7F, 0, 1, 0, 16'hA1B2), 16'hA1B2, 0);
    access("R1", 2'd1, 1, 1, 25'h3A5, 16'h1234, 1, mk(3, 1, 23'h25, 1, 1, 16'h1234, 16'hFFFF), 0, 0);
    access("R2", 2'd1, 1, 0, 25'h012, 16'h0055, 1, mk(0, 0, 23'h12, 1, 0, 16'h0055, 16'hFFFF), 0, 0);
    // R5 interrupt acknowledge
    access("R5", 2'd1, 0, 0, 25'h1C0, 0, 1, mk(1, 2, 0, 0, 0, 0, 16'h0077), 16'h0077, 8'h04);
    access("R5", 2'd1, 0, 0, 25'h0C2, 0, 1, mk(0, 2, 2, 0, 0, 0, 16'h0011), 16'h0011, 8'h00);
    access("R5", 2'd1, 0, 0, 25'h3C2, 0, 1, mk(3, 2, 2, 0, 0, 0, 16'h0022), 16'h0022, 8'h80);
    access("R5", 2'd1, 0, 0, 25'h3C1, 0, 1, mk(3, 2, 1, 0, 0, 0, 16'h0033), 16'h0033, 8'h00);
    // R6 memory windows
    access("R6", 2'd2, 0, 1, 25'h1812345, 0, 1, mk(3, 3, 23'h12345, 0, 1, 0, 16'hBEEF), 16'hBEEF, 0);
    access("R6", 2'd3, 1, 0, 25'h042ABCD, 16'h00C3, 1, mk(1, 4, 23'h2ABCD, 1, 0, 16'h00C3, 16'hFFFF), 0, 0);
    // R7 absent slot 2
    access("R7", 2'd1, 0, 1, 25'h240, 0, 0, none, 0, 0);
    access("R7", 2'd2, 1, 1, 25'h1000000, 16'hFFFF, 0, none, 0, 0);
    access("R7", 2'd1, 0, 0, 25'h2C0, 0, 0, none, 0, 0);
    // R9 size rejection
    access("R9", 2'd3, 0, 1, 25'h0000000, 0, 0, none, 0, 0);
    access("R9", 2'd0, 1, 1, 25'h02F, 16'h0001, 0, none, 0, 0);
    access("R9", 2'd0, 0, 0, 25'h02F, 0, 0, none, 0, 0);
    // R8 configuration flags
    access("R8", 2'd0, 1, 0, 25'h02F, 16'h0001, 0, none, 0, 0);
    access("R8", 2'd0, 0, 0, 25'h02F, 0, 0, none, 16'h0001, 0);
    access("R8", 2'd0, 1, 0, 25'h033, 16'h0001, 0, none, 0, 0);
    access("R8", 2'd0, 1, 0, 25'h02B, 16'h00FF, 0, none, 0, 0);
    chk(be_ctl == 1'b1, "R8", "be_ctl", 32'(be_ctl), 1);
    access("R8", 2'd0, 1, 0, 25'h02C, 16'h0001, 0, none, 0, 0);
    access("R8", 2'd0, 0, 0, 25'h02C, 0, 0, none, 16'h0000, 0);
    access("R9", 2'd0, 0, 1, 25'h02B, 0, 0, none, 16'h0000, 0);
    // R3 big-endian byte address flip
    access("R3", 2'd1, 0, 0, 25'h1C1, 0, 1, mk(1, 2, 0, 0, 0, 0, 16'h0044), 16'h0044, 8'h04);
    access("R3", 2'd2, 1, 0, 25'h0800010, 16'h0066, 1, mk(1, 3, 23'h11, 1, 0, 16'h0066, 16'hFFFF), 0, 0);
    // R4 big-endian halfword swap
    access("R4", 2'd1, 1, 1, 25'h300, 16'h1234, 1, mk(3, 0, 0, 1, 1, 16'h3412, 16'hFFFF), 0, 0);
    access("R4", 2'd2, 0, 1, 25'h0000100, 0, 1, mk(0, 3, 23'h100, 0, 1, 0, 16'hA1B2), 16'hB2A1, 0);
    // R6 8-bit window ignores endian flags
    access("R6", 2'd3, 0, 0, 25'h0000001, 0, 1, mk(0, 4, 1, 0, 0, 0, 16'h005A), 16'h005A, 0);
    // R8 clear register-window flag, then no flip
    access("R8", 2'd0, 1, 0, 25'h02F, 16'h00FE, 0, none, 0, 0);
    access("R8", 2'd0, 0, 0, 25'h02F, 0, 0, none, 16'h0000, 0);
    access("R3", 2'd1, 0, 0, 25'h001, 0, 1, mk(0, 0, 1, 0, 0, 0, 16'h0009), 16'h0009, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule